// File: doc/BRIEF.md
# Temperature-Based Reference Current Calculator

This block converts the readings of four on-die temperature sensors into ten digital target-current codes, one for each gamma tap of an emissive display. The codes feed a current DAC whose output is matched against a dummy pixel elsewhere on the chip. Because emitter efficiency rises with temperature, the drive current needed for a fixed full-scale brightness falls as the die warms. The block works out that current once per compensation cycle.

A one-cycle start pulse captures the four readings and takes their mean. The mean selects an entry of a linear efficiency table. A sequential divider then produces the full-scale drive current as the stored full-scale luminance divided by that efficiency. Each of the ten taps then receives the full-scale current scaled by its own stored ratio. The ten codes leave the block one per cycle, brightest tap first, each with a tap index and a valid strobe. A done pulse follows the last code. A zero efficiency entry cannot be divided by, so in that case every code is forced to full scale and an error flag is raised.

Top module: `tcomp_iref_calc`

## Requirements
- R1: The working temperature is the floor (rounded toward minus infinity) of the sum of the four two's-complement TEMP_W-bit readings divided by 4. Sensor k occupies bits [k*TEMP_W +: TEMP_W] of `temp_i`.
- R2: The table index is (working temperature − T_BASE) >> STEP_SH, clamped to 0 below and DEPTH−1 above. The efficiency entry at index j is EFF_BASE + EFF_SLOPE·j.
- R3: The full-scale current is floor(FS_LUM / efficiency). Tap 0 has ratio 256/256, so its code equals the full-scale current.
- R4: The code for tap k is min(floor(full-scale current × ratio[k] / 256), 2^IREF_W − 1). The ratios for taps 0..9 are 256, 134, 72, 31, 13, 5, 2, 1, 1, 1.
- R5: Codes are emitted on ten consecutive cycles with `valid_o` high. `tap_o` runs 0 to 9, and tap index k stands for gray levels 255, 190, 144, 98, 65, 40, 21, 10, 5, 1 in that order.
- R6: `busy_o` is high from the cycle after an accepted start until the cycle holding the done pulse. `done_o` is high for exactly one cycle, the cycle after the last code, and exactly one done pulse is issued per accepted start.
- R7: If the selected efficiency entry is zero, `err_o` goes high and all ten codes are 2^IREF_W − 1. `err_o` holds until the next accepted start, which clears it.
- R8: The readings are captured only on the start cycle. A start pulse while busy is ignored and does not restart or extend the computation.
- R9: After reset `busy_o`, `valid_o`, `done_o` and `err_o` are low, and `tap_o` and `iref_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| temp_i | input | 4*TEMP_W | Four signed temperature readings |
| busy_o | output | 1 | Computation in progress |
| valid_o | output | 1 | `tap_o` / `iref_o` carry a result |
| tap_o | output | 4 | Tap index, 0 = brightest |
| iref_o | output | IREF_W | Reference current code |
| done_o | output | 1 | One-cycle end-of-cycle pulse |
| err_o | output | 1 | Zero efficiency entry hit |

## Verification
The bench sweeps the mean temperature one degree at a time across and beyond the whole table, so every efficiency bucket and both clamps are reached. Three sensor patterns are used in rotation: equal readings, a narrow spread and a wide spread. Unequal readings separate a true mean from a reading picked by position. Chosen sums just below a bucket edge, at both negative and positive temperatures, separate floor rounding from truncation or round-up. A second instance whose first efficiency entry is zero checks saturation and the clearing of the error flag. A restart attempted mid-run together with changed readings checks that inputs are captured once and that starts while busy are ignored.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;
  localparam int NTAP       = 10;
  localparam int TAP_W      = 4;
  localparam int RATIO_W    = 9;
  localparam int RATIO_FRAC = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_IDX, ST_EFF, ST_DIVS, ST_DIV, ST_EMIT, ST_DONE
  } state_e;

  // per-tap current ratio in units of 1/256, tap 0 = brightest
  function automatic logic [RATIO_W-1:0] tap_ratio(input logic [TAP_W-1:0] k);
    case (k)
      4'd0:    tap_ratio = 9'd256;
      4'd1:    tap_ratio = 9'd134;
      4'd2:    tap_ratio = 9'd72;
      4'd3:    tap_ratio = 9'd31;
      4'd4:    tap_ratio = 9'd13;
      4'd5:    tap_ratio = 9'd5;
      4'd6:    tap_ratio = 9'd2;
      default: tap_ratio = 9'd1;
    endcase
  endfunction
endpackage

// File: rtl/tcomp_temp_avg.sv
module tcomp_temp_avg #(
  parameter int TEMP_W  = 10,
  parameter int T_BASE  = -48,
  parameter int STEP_SH = 3,
  parameter int DEPTH   = 16
) (
  input  logic [4*TEMP_W-1:0]       temp_i,
  output logic [$clog2(DEPTH)-1:0]  idx_o
);
  localparam int SUM_W = TEMP_W + 2;
  localparam int IDX_W = $clog2(DEPTH);

  logic signed [SUM_W-1:0] ext [4];
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] avg;
  logic signed [31:0]      off;
  logic signed [31:0]      bucket;

  for (genvar g = 0; g < 4; g++) begin : g_ext
    assign ext[g] = {{2{temp_i[g*TEMP_W+TEMP_W-1]}}, temp_i[g*TEMP_W +: TEMP_W]};
  end

  assign sum    = ext[0] + ext[1] + ext[2] + ext[3];
  assign avg    = sum >>> 2;  // floor division by 4
  assign off    = 32'(avg) - 32'(T_BASE);
  assign bucket = off >>> STEP_SH;

  always_comb begin
    if (off < 0)                    idx_o = '0;
    else if (bucket > 32'(DEPTH-1)) idx_o = IDX_W'(DEPTH-1);
    else                            idx_o = bucket[IDX_W-1:0];
  end

  always_comb begin
    a_idx_in_table_r2: assert (32'(idx_o) <= DEPTH-1);
  end
endmodule

// File: rtl/tcomp_eff_rom.sv
module tcomp_eff_rom #(
  parameter int DEPTH     = 16,
  parameter int EFF_W     = 8,
  parameter int EFF_BASE  = 28,
  parameter int EFF_SLOPE = 1
) (
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  output logic [EFF_W-1:0]         eff_o
);
  // linear efficiency model, computed rather than stored
  assign eff_o = EFF_W'(EFF_BASE + EFF_SLOPE * int'(idx_i));
endmodule

// File: rtl/tcomp_div.sv
module tcomp_div #(
  parameter int N = 16,
  parameter int D = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] dividend_i,
  input  logic [D-1:0] divisor_i,
  output logic         done_o,
  output logic [N-1:0] quot_o
);
  localparam int CNT_W = $clog2(N + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [D:0]       rem_q;
  logic [N-1:0]     quot_q;
  logic [D-1:0]     div_q;
  logic [D:0]       trial;
  logic             ge;

  assign trial  = {rem_q[D-1:0], quot_q[N-1]};
  assign ge     = trial >= {1'b0, div_q};
  assign quot_o = quot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quot_q <= '0;
      div_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(N);
        rem_q  <= '0;
        quot_q <= dividend_i;
        div_q  <= divisor_i;
      end else if (busy_q) begin
        rem_q  <= ge ? (trial - {1'b0, div_q}) : trial;
        quot_q <= {quot_q[N-2:0], ge};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  p_rem_lt_div_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q < {1'b0, div_q});
  p_nonzero_div_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |-> divisor_i != '0);
  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/tcomp_tap_scale.sv
module tcomp_tap_scale
  import tcomp_pkg::*;
#(
  parameter int LUM_W  = 16,
  parameter int IREF_W = 16
) (
  input  logic [LUM_W-1:0]  fs_i,
  input  logic [TAP_W-1:0]  tap_i,
  input  logic              sat_i,
  output logic [IREF_W-1:0] code_o
);
  localparam int PW = LUM_W + RATIO_W;
  localparam logic [PW-1:0] MAXV = PW'((64'(1) << IREF_W) - 1);

  logic [PW-1:0] prod;
  logic [PW-1:0] scaled;

  assign prod   = PW'(fs_i) * PW'(tap_ratio(tap_i));
  assign scaled = prod >> RATIO_FRAC;

  always_comb begin
    if (sat_i || scaled > MAXV) code_o = '1;
    else                        code_o = scaled[IREF_W-1:0];
  end
endmodule

// File: rtl/tcomp_iref_calc.sv
module tcomp_iref_calc
  import tcomp_pkg::*;
#(
  parameter int TEMP_W    = 10,
  parameter int T_BASE    = -48,
  parameter int STEP_SH   = 3,
  parameter int DEPTH     = 16,
  parameter int EFF_W     = 8,
  parameter int EFF_BASE  = 28,
  parameter int EFF_SLOPE = 1,
  parameter int LUM_W     = 16,
  parameter int FS_LUM    = 60000,
  parameter int IREF_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [4*TEMP_W-1:0] temp_i,
  output logic                busy_o,
  output logic                valid_o,
  output logic [TAP_W-1:0]    tap_o,
  output logic [IREF_W-1:0]   iref_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [LUM_W-1:0] FS_VAL = LUM_W'(FS_LUM);

  state_e              state_q;
  logic [4*TEMP_W-1:0] temp_q;
  logic [IDX_W-1:0]    idx_q, idx_w;
  logic [EFF_W-1:0]    eff_q, eff_w;
  logic [LUM_W-1:0]    fs_q, quot_w;
  logic [TAP_W-1:0]    tap_q;
  logic [IREF_W-1:0]   code_w;
  logic                div_start, div_done;

  tcomp_temp_avg #(
    .TEMP_W(TEMP_W), .T_BASE(T_BASE), .STEP_SH(STEP_SH), .DEPTH(DEPTH)
  ) u_avg (
    .temp_i(temp_q), .idx_o(idx_w)
  );

  tcomp_eff_rom #(
    .DEPTH(DEPTH), .EFF_W(EFF_W), .EFF_BASE(EFF_BASE), .EFF_SLOPE(EFF_SLOPE)
  ) u_rom (
    .idx_i(idx_q), .eff_o(eff_w)
  );

  assign div_start = (state_q == ST_DIVS) && (eff_q != '0);

  tcomp_div #(.N(LUM_W), .D(EFF_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .dividend_i(FS_VAL), .divisor_i(eff_q),
    .done_o(div_done), .quot_o(quot_w)
  );

  tcomp_tap_scale #(.LUM_W(LUM_W), .IREF_W(IREF_W)) u_scale (
    .fs_i(fs_q), .tap_i(tap_q), .sat_i(err_o), .code_o(code_w)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      temp_q  <= '0;
      idx_q   <= '0;
      eff_q   <= '0;
      fs_q    <= '0;
      tap_q   <= '0;
      err_o   <= 1'b0;
      valid_o <= 1'b0;
      tap_o   <= '0;
      iref_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          temp_q  <= temp_i;
          err_o   <= 1'b0;
          state_q <= ST_IDX;
        end
        ST_IDX: begin
          idx_q   <= idx_w;
          state_q <= ST_EFF;
        end
        ST_EFF: begin
          eff_q   <= eff_w;
          state_q <= ST_DIVS;
        end
        ST_DIVS: begin
          tap_q <= '0;
          if (eff_q == '0) begin
            err_o   <= 1'b1;
            fs_q    <= '1;
            state_q <= ST_EMIT;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          fs_q    <= quot_w;
          state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          valid_o <= 1'b1;
          tap_o   <= tap_q;
          iref_o  <= code_w;
          if (tap_q == TAP_W'(NTAP-1)) state_q <= ST_DONE;
          else                         tap_q   <= tap_q + 1'b1;
        end
        ST_DONE: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_tap_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> tap_o < TAP_W'(NTAP));
  p_first_tap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> tap_o == '0);
  p_tap_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> tap_o == $past(tap_o) + 1'b1);
  p_done_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_o) && $past(tap_o) == TAP_W'(NTAP-1) && !valid_o));
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_sat_on_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> iref_o == '1);
  p_temp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> $stable(temp_q));
endmodule

// File: tb/sim_tcomp_iref_calc.sv
`timescale 1ns/1ps
module sim_tcomp_iref_calc;
  localparam int TEMP_W = 10, T_BASE = -48, STEP_SH = 3, DEPTH = 16;
  localparam int EFF_SLOPE = 1, FS_LUM = 60000, IREF_W = 16;
  localparam int MAXC = 65535;
  localparam int RAT [10] = '{256, 134, 72, 31, 13, 5, 2, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] start = 2'b00;
  logic [4*TEMP_W-1:0] temp = '0;
  logic busy_w [2], valid_w [2], done_w [2], err_w [2];
  logic [3:0] tap_w [2];
  logic [IREF_W-1:0] iref_w [2];

  int checks = 0, errors = 0;
  int cap [2][10];
  int vcnt [2], dcnt [2], obad [2];

  always #10 clk = ~clk;

  tcomp_iref_calc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start[0]), .temp_i(temp),
    .busy_o(busy_w[0]), .valid_o(valid_w[0]), .tap_o(tap_w[0]),
    .iref_o(iref_w[0]), .done_o(done_w[0]), .err_o(err_w[0])
  );

  tcomp_iref_calc #(.EFF_BASE(0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start[1]), .temp_i(temp),
    .busy_o(busy_w[1]), .valid_o(valid_w[1]), .tap_o(tap_w[1]),
    .iref_o(iref_w[1]), .done_o(done_w[1]), .err_o(err_w[1])
  );

  always @(negedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (valid_w[s]) begin
        if (int'(tap_w[s]) != vcnt[s] || vcnt[s] > 9) obad[s]++;
        else cap[s][vcnt[s]] = int'(iref_w[s]);
        vcnt[s]++;
      end
      if (done_w[s]) dcnt[s]++;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_idx(input int a, input int b, input int c, input int d);
    int s, avg, off, bk;
    s   = a + b + c + d;
    avg = s >>> 2;
    off = avg - T_BASE;
    if (off < 0) return 0;
    bk = off >>> STEP_SH;
    if (bk > DEPTH - 1) return DEPTH - 1;
    return bk;
  endfunction

  function automatic int exp_code(input int eff, input int k);
    int fs, v;
    if (eff == 0) return MAXC;
    fs = FS_LUM / eff;
    v  = (fs * RAT[k]) >>> 8;
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic set_temp(input int a, input int b, input int c, input int d);
    temp = {TEMP_W'(d), TEMP_W'(c), TEMP_W'(b), TEMP_W'(a)};
  endtask

  task automatic launch(input int s);
    vcnt[s] = 0; dcnt[s] = 0; obad[s] = 0;
    start[s] = 1'b1;
    @(negedge clk);
    start[s] = 1'b0;
  endtask

  task automatic wait_done(input int s);
    for (int i = 0; i < 200 && dcnt[s] == 0; i++) @(negedge clk);
  endtask

  task automatic check_run(input int s, input int eff);
    for (int k = 0; k < 10; k++)
      chk(k == 0 ? "R3 full-scale (tap0)" : "R4 tap code", cap[s][k], exp_code(eff, k));
    chk("R5 valid count", vcnt[s], 10);
    chk("R5 tap order", obad[s], 0);
    chk("R6 done pulses", dcnt[s], 1);
    chk("R6 busy at done", int'(busy_w[s]), 0);
    chk("R7 err flag", int'(err_w[s]), (eff == 0) ? 1 : 0);
  endtask

  task automatic run_case(input int s, input int eff_base,
                          input int a, input int b, input int c, input int d);
    int eff;
    eff = eff_base + EFF_SLOPE * exp_idx(a, b, c, d);
    set_temp(a, b, c, d);
    launch(s);
    chk("R6 busy after start", int'(busy_w[s]), 1);
    wait_done(s);
    check_run(s, eff);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin vcnt[s] = 0; dcnt[s] = 0; obad[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", int'(busy_w[0]), 0);
    chk("R9 valid", int'(valid_w[0]), 0);
    chk("R9 done", int'(done_w[0]), 0);
    chk("R9 err", int'(err_w[0]), 0);
    chk("R9 tap", int'(tap_w[0]), 0);
    chk("R9 iref", int'(iref_w[0]), 0);

    // R1 floor rounding at bucket edges, negative and positive
    run_case(0, 28, -40, -40, -40, -41);
    chk("R1 negative floor", cap[0][0], FS_LUM / 28);
    run_case(0, 28, 31, 32, 32, 32);
    chk("R1 positive floor", cap[0][0], FS_LUM / (28 + 9));
    // R2 clamps at both extremes
    run_case(0, 28, 511, 511, 511, 511);
    chk("R2 upper clamp", cap[0][0], FS_LUM / (28 + 15));
    run_case(0, 28, -512, -512, -512, -512);
    chk("R2 lower clamp", cap[0][0], FS_LUM / 28);

    // R1 R2 R3 R4 sweep with three spread patterns
    for (int t = -70; t <= 100; t++) begin
      case (t % 3)
        0:       run_case(0, 28, t, t, t, t);
        1, -1:   run_case(0, 28, t - 3, t + 3, t - 1, t + 2);
        default: run_case(0, 28, t - 7, t + 5, t, t + 1);
      endcase
    end

    // R8 restart while busy ignored, inputs captured at start
    set_temp(-45, -45, -45, -45);
    launch(0);
    repeat (5) @(negedge clk);
    set_temp(90, 90, 90, 90);
    start[0] = 1'b1;
    @(negedge clk);
    start[0] = 1'b0;
    wait_done(0);
    check_run(0, 28 + exp_idx(-45, -45, -45, -45));
    repeat (30) @(negedge clk);
    chk("R8 no second run valids", vcnt[0], 10);
    chk("R8 no second done", dcnt[0], 1);

    // R7 zero efficiency entry on second instance
    run_case(1, 0, -60, -60, -60, -60);
    repeat (4) @(negedge clk);
    chk("R7 err held", int'(err_w[1]), 1);
    run_case(1, 0, -40, -40, -40, -40);
    chk("R7 err cleared value", cap[1][0], FS_LUM);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule